// File: doc/BRIEF.md
# SM3 Compression Round Step Unit

This block advances the SM3 working state by one compression step. The state is a 128-bit vector D made of four 32-bit lanes. Lane k occupies bits [32k+31:32k]. A 2-bit opcode selects one of four round-step variants. Each variant combines a boolean function of the upper three lanes with the lowest lane, with one lane of a message vector M picked by a 2-bit lane selector, and with the top lane of a source vector N. The step then shifts the state down one lane and applies the rotations that belong to the variant.

A separate mode computes the SS1 intermediate from the top lanes of N, M and a third source A. Only the top lane of N and of A is ever used, so those two ports carry just that lane.

The caller puts the operands on the inputs and raises `start` for one cycle. The updated vector appears on `result` in the next cycle, and `done` is high in that same cycle. Message expansion, round constants, round counting and the final hash output are handled outside this block.

Top module: `sm3_step_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `result` to zero and `done` to 0, and it takes priority over a `start` in the same cycle.
- R2: `done` is 1 in exactly the cycle after a clock edge at which `start` was 1 (and `rst` was 0), and 0 otherwise. Back-to-back starts give back-to-back `done` cycles.
- R3: While `start` is 0, `result` keeps its previous value.
- R4: With `mode`=0 the boolean term f is taken on x=D[3], y=D[2], z=D[1]:
  - opcodes 0 and 2 use parity, x^y^z;
  - opcode 1 uses majority, where each bit is 1 when at least two of x, y, z are 1;
  - opcode 3 uses choose, where each bit is y where x is 1 and z where x is 0.
- R5: With `mode`=0, `lane_sel` (0..3) picks which M lane, M[lane_sel], is added into the sum t0 = f + D[0] + M[lane_sel].
- R6: Opcodes 0 and 1:
  - t = t0 + (N3 ^ ror(D[3],20));
  - new lane 1 = ror(D[2],23).
- R7: Opcodes 2 and 3:
  - s = t0 + N3 and t = s ^ rol(s,9) ^ rol(s,17);
  - new lane 1 = ror(D[2],13).
- R8: In every mode-0 step, new lane 0 = old D[1], new lane 2 = old D[3], and new lane 3 = t.
- R9: With `mode`=1:
  - lane 3 of the result = ror(ror(N3,20) + M[3] + A3, 25);
  - lanes 0 to 2 are zero;
  - `opcode` and `lane_sel` have no effect.
- R10: Every addition wraps modulo 2^32 and drops the carry out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch one step using the current inputs |
| mode | input | 1 | 0 = round step, 1 = SS1 computation |
| opcode | input | 2 | Round-step variant (0..3) |
| lane_sel | input | 2 | Index of the M lane used by a round step |
| d_in | input | 128 | Current state vector D |
| m_in | input | 128 | Message vector M |
| n_top | input | 32 | Top lane of source vector N |
| a_top | input | 32 | Top lane of source vector A (SS1 only) |
| result | output | 128 | Registered updated vector |
| done | output | 1 | High for one cycle when `result` is new |

## Verification
Two things can happen in the same cycle: a reset can coincide with a start, and a new start can arrive while `done` from the previous step is still high. The bench provokes both. It raises `rst` together with `start` and expects a cleared result with `done` low. It also issues unbroken runs of starts across every opcode and lane selector and expects each cycle's result to match only the operands of the previous edge, with `done` staying high throughout. A behavioural model in the bench predicts the registered outputs after every edge. The all-zero and all-one operand sets expose any carry that is not dropped.

// File: rtl/sm3_step_pkg.sv
package sm3_step_pkg;
    localparam int WORD_W = 32;
    localparam int LANE_N = 4;
    localparam int VEC_W  = WORD_W * LANE_N;
    localparam int SEL_W  = $clog2(LANE_N);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [VEC_W-1:0]  vec_t;

    // bit 1 of the opcode separates the two families; bit 0 picks the function
    typedef enum logic [1:0] {
        OP_T1_PAR = 2'd0,
        OP_T1_MAJ = 2'd1,
        OP_T2_PAR = 2'd2,
        OP_T2_CHO = 2'd3
    } step_op_e;

    typedef struct packed {
        vec_t result;
        logic done;
    } step_regs_t;

    function automatic word_t rotr(input word_t x, input int unsigned s);
        return (x >> s) | (x << (WORD_W - s));
    endfunction
endpackage

// File: rtl/sm3_bool_sel.sv
module sm3_bool_sel
    import sm3_step_pkg::*;
(
    input  logic [1:0] op,
    input  word_t      x,
    input  word_t      y,
    input  word_t      z,
    output word_t      f
);
    // R4: function chosen by opcode
    always_comb begin
        case (op)
            OP_T1_MAJ: f = (x & y) | (x & z) | (y & z);
            OP_T2_CHO: f = (x & y) | (~x & z);
            default:   f = x ^ y ^ z;
        endcase
    end
endmodule

// File: rtl/sm3_tt_round.sv
module sm3_tt_round
    import sm3_step_pkg::*;
(
    input  logic [1:0]       op,
    input  logic [SEL_W-1:0] lane_sel,
    input  vec_t             d_vec,
    input  vec_t             m_vec,
    input  word_t            n_hi,
    output vec_t             out_vec
);
    word_t d_w [LANE_N];
    word_t m_w [LANE_N];

    for (genvar g = 0; g < LANE_N; g++) begin : g_unpack
        assign d_w[g] = d_vec[g*WORD_W +: WORD_W];
        assign m_w[g] = m_vec[g*WORD_W +: WORD_W];
    end

    word_t f_val;

    sm3_bool_sel u_bool (
        .op (op),
        .x  (d_w[3]),
        .y  (d_w[2]),
        .z  (d_w[1]),
        .f  (f_val)
    );

    word_t t_base;
    word_t t_fam2;
    word_t t_new;
    word_t lane1_new;

    always_comb begin
        // R5, R10: modulo-2^32 sum with selected M lane
        t_base = f_val + d_w[0] + m_w[lane_sel];
        t_fam2 = t_base + n_hi;
        if (op[1] == 1'b0) begin
            // R6
            t_new     = t_base + (n_hi ^ rotr(d_w[3], 20));
            lane1_new = rotr(d_w[2], 23);
        end else begin
            // R7: left rotates by 9 and 17 as right rotates by 23 and 15
            t_new     = t_fam2 ^ rotr(t_fam2, 23) ^ rotr(t_fam2, 15);
            lane1_new = rotr(d_w[2], 13);
        end
        // R8: lane shift
        out_vec = {t_new, d_w[3], lane1_new, d_w[1]};
    end
endmodule

// File: rtl/sm3_ss1_calc.sv
module sm3_ss1_calc
    import sm3_step_pkg::*;
(
    input  word_t n_hi,
    input  word_t m_hi,
    input  word_t a_hi,
    output vec_t  out_vec
);
    word_t sum;

    always_comb begin
        // R9, R10
        sum     = rotr(n_hi, 20) + m_hi + a_hi;
        out_vec = '0;
        out_vec[VEC_W-1 -: WORD_W] = rotr(sum, 25);
    end
endmodule

// File: rtl/sm3_step_unit.sv
module sm3_step_unit
    import sm3_step_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         mode,
    input  logic [1:0]   opcode,
    input  logic [1:0]   lane_sel,
    input  logic [127:0] d_in,
    input  logic [127:0] m_in,
    input  logic [31:0]  n_top,
    input  logic [31:0]  a_top,
    output logic [127:0] result,
    output logic         done
);
    vec_t       tt_vec;
    vec_t       ss1_vec;
    step_regs_t step_d;
    step_regs_t step_q;

    sm3_tt_round u_tt (
        .op       (opcode),
        .lane_sel (lane_sel),
        .d_vec    (d_in),
        .m_vec    (m_in),
        .n_hi     (n_top),
        .out_vec  (tt_vec)
    );

    sm3_ss1_calc u_ss1 (
        .n_hi    (n_top),
        .m_hi    (m_in[VEC_W-1 -: WORD_W]),
        .a_hi    (a_top),
        .out_vec (ss1_vec)
    );

    always_comb begin
        step_d      = step_q;
        step_d.done = 1'b0;            // R2
        if (start) begin
            step_d.done   = 1'b1;
            step_d.result = mode ? ss1_vec : tt_vec;   // R9 selects SS1
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;          // R1
        else     step_q <= step_d;
    end

    assign result = step_q.result;
    assign done   = step_q.done;
endmodule

// File: rtl/sm3_step_chk.sv
module sm3_step_chk (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         mode,
    input logic [127:0] d_in,
    input logic [127:0] result,
    input logic         done
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (result == '0) && !done);

    a_r2_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    a_r2_done_idle_low: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);

    a_r3_hold_result: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));

    a_r8_lane_shift: assert property (@(posedge clk) disable iff (rst)
        (start && !mode) |=> (result[31:0] == $past(d_in[63:32]))
                          && (result[95:64] == $past(d_in[127:96])));

    a_r9_low_lanes_zero: assert property (@(posedge clk) disable iff (rst)
        (start && mode) |=> (result[95:0] == '0));
endmodule

bind sm3_step_unit sm3_step_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .mode   (mode),
    .d_in   (d_in),
    .result (result),
    .done   (done)
);

// File: tb/sm3_step_unit_bench.sv
`timescale 1ns/1ps
module sm3_step_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic [1:0]   opcode = '0;
    logic [1:0]   lane_sel = '0;
    logic [127:0] d_in = '0;
    logic [127:0] m_in = '0;
    logic [31:0]  n_top = '0;
    logic [31:0]  a_top = '0;
    logic [127:0] result;
    logic         done;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [127:0] exp_res = '0;
    logic         exp_done = 1'b0;

    always #2.5 clk = ~clk;

    sm3_step_unit u_sm3_step_unit (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .opcode(opcode),
        .lane_sel(lane_sel), .d_in(d_in), .m_in(m_in), .n_top(n_top),
        .a_top(a_top), .result(result), .done(done)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        logic [63:0] w;
        w = {x, x} >> n;
        return w[31:0];
    endfunction

    function automatic logic [31:0] lanew(input logic [127:0] v, input int k);
        return v[k*32 +: 32];
    endfunction

    // behavioural reference for R4..R10
    function automatic logic [127:0] model(input logic md, input int op, input int ls,
                                           input logic [127:0] d, input logic [127:0] m,
                                           input logic [31:0] n, input logic [31:0] a);
        logic [31:0] x, y, z, f, t, l1;
        logic [127:0] r;
        longint s;
        if (md) begin
            s = longint'(rr(n, 20)) + longint'(lanew(m, 3)) + longint'(a);
            r = '0;
            r[127:96] = rr(s[31:0], 25);
            return r;
        end
        x = lanew(d, 3); y = lanew(d, 2); z = lanew(d, 1);
        for (int i = 0; i < 32; i++) begin
            case (op)
                1: f[i] = (int'(x[i]) + int'(y[i]) + int'(z[i])) >= 2;
                3: f[i] = x[i] ? y[i] : z[i];
                default: f[i] = x[i] ^ y[i] ^ z[i];
            endcase
        end
        s = longint'(f) + longint'(lanew(d, 0)) + longint'(lanew(m, ls));
        if (op < 2) begin
            s = s + longint'(n ^ rr(x, 20));
            t = s[31:0];
            l1 = rr(y, 23);
        end else begin
            s = s + longint'(n);
            t = s[31:0];
            t = t ^ rr(t, 32 - 9) ^ rr(t, 32 - 17);
            l1 = rr(y, 13);
        end
        return {t, x, l1, z};
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cycle(input logic r, input logic st, input logic md,
                             input int op, input int ls,
                             input logic [127:0] d, input logic [127:0] m,
                             input logic [31:0] n, input logic [31:0] a,
                             input string tag);
        rst = r; start = st; mode = md;
        opcode = 2'(op); lane_sel = 2'(ls);
        d_in = d; m_in = m; n_top = n; a_top = a;
        @(posedge clk);
        if (r) begin
            exp_res = '0; exp_done = 1'b0;
        end else if (st) begin
            exp_res = model(md, op, ls, d, m, n, a); exp_done = 1'b1;
        end else begin
            exp_done = 1'b0;
        end
        @(negedge clk);
        check({tag, " result"}, result, exp_res);
        check(r ? "R1 done" : "R2 done", {127'b0, done}, {127'b0, exp_done});
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [127:0] d, m;
        logic [31:0] n, a, ss_ref;
        @(negedge clk);
        run_cycle(1, 0, 0, 0, 0, '0, '0, 0, 0, "R1");
        run_cycle(1, 0, 0, 0, 0, '0, '0, 0, 0, "R1");

        // R4 R5 R6 R7 R8 R10: every opcode and lane, zeros, ones, random
        for (int p = 0; p < 22; p++) begin
            for (int op = 0; op < 4; op++) begin
                for (int ls = 0; ls < 4; ls++) begin
                    if (p == 0) begin d = '0; m = '0; n = '0; end
                    else if (p == 1) begin d = '1; m = '1; n = '1; end
                    else begin d = rnd128(); m = rnd128(); n = $urandom; end
                    run_cycle(0, 1, 0, op, ls, d, m, n, $urandom,
                              op < 2 ? "R4 R5 R6 R8 R10" : "R4 R5 R7 R8 R10");
                end
            end
            // R3: idle cycle holds value with fresh inputs
            run_cycle(0, 0, 0, p % 4, 0, rnd128(), rnd128(), $urandom, $urandom, "R3");
        end

        // R9: SS1, opcode and lane_sel varied, same answer expected
        for (int k = 0; k < 12; k++) begin
            d = rnd128(); m = (k == 0) ? '1 : rnd128();
            n = (k == 0) ? '1 : $urandom; a = (k == 0) ? '1 : $urandom;
            ss_ref = 32'(model(1, 0, 0, d, m, n, a) >> 96);
            for (int op = 0; op < 4; op++) begin
                run_cycle(0, 1, 1, op, 3 - op, d, m, n, a, "R9 R10");
                check("R9 ignored fields", {96'b0, result[127:96]}, {96'b0, ss_ref});
            end
        end

        // R1: reset together with start wins
        run_cycle(0, 1, 0, 1, 2, rnd128(), rnd128(), $urandom, 0, "R4 R8");
        run_cycle(1, 1, 0, 2, 1, rnd128(), rnd128(), $urandom, 0, "R1");
        // R2: back-to-back after reset, then idle
        run_cycle(0, 1, 0, 3, 3, rnd128(), rnd128(), $urandom, 0, "R2 R7");
        run_cycle(0, 1, 1, 0, 0, rnd128(), rnd128(), $urandom, $urandom, "R2 R9");
        run_cycle(0, 0, 0, 0, 0, rnd128(), rnd128(), $urandom, 0, "R3");
        run_cycle(0, 0, 1, 2, 2, rnd128(), rnd128(), $urandom, 0, "R3");

        finish_run();
    end
endmodule